// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Overrun Detection

This block is the receive half of a clock-synchronous serial port. An external serial clock and data line are brought into the system clock domain through a synchroniser. On every rising edge of the serial clock one data bit is shifted in, least significant bit first. After eight bits the frame is copied into a receive buffer register, and a complete flag is raised. If that flag is still set when the next frame lands, the buffer is overwritten anyway and a sticky overrun flag is set. Software can clear the overrun flag only by turning reception off.

Software controls the block through a small register interface with three locations. Address 0 is control: bits [2:0] are the serial mode (001 = clock-synchronous, 000 = port off), bit 3 enables reception, bit 4 selects the interrupt mode (0 = every frame, 1 = overrun only) and bit 5 holds the transmit enable that this block shares with the transmit side. Address 1 reads the receive buffer. Address 2 is status: bit 0 is receive-complete, bit 1 is overrun and bit 2 is the interrupt request, which also drives the `irq` pin. Reads return data on `rdata` combinationally from `addr`. A read strobe on address 1 marks the buffer as consumed.

Top module: `ssr_rx`

## Requirements
- R1: After reset the control word, the receive buffer and the status word all read 0, and `irq` is low.
- R2: With control mode 001 and receive enable 1, eight rising serial-clock edges deliver one frame. The first bit sampled is bit 0. The frame appears in the buffer (address 1) and sets status bit 0.
- R3: A read strobe on address 1 clears status bit 0 and leaves status bit 1 unchanged.
- R4: A frame that completes while status bit 0 is already 1 sets status bit 1. Its data still replaces the buffer contents.
- R5: Writing control with bit 3 = 0 clears status bits 0 and 1 and sets the buffer to 0.
- R6: With control bit 4 = 0, every completed frame sets status bit 2 and `irq`.
- R7: With control bit 4 = 1, a frame sets status bit 2 only when it causes an overrun. A frame that finds status bit 0 clear leaves status bit 2 at 0.
- R8: A write to address 2 with bit 2 = 0 clears the interrupt request. A write with bit 2 = 1 leaves it unchanged.
- R9: While the mode field is not 001 or receive enable is 0, no frame is received, and any bits already shifted in are discarded.
- R10: A control write whose mode field is not 001 stores transmit enable (bit 5) as 0. A write with mode 001 stores bit 5 as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | External serial clock, asynchronous to clk |
| sdat_in | input | 1 | Serial data, sampled on serial-clock rising edges |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 control, 1 buffer, 2 status) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from addr |
| irq | output | 1 | Receive interrupt request (status bit 2) |

## Verification
Suppose the bit counter or the shift register picks up a wrong value, for example from a stray bit left over after the port is disabled. The next buffer read then shows rotated or mixed data, one full frame later. A complete or overrun flag that is set or cleared at the wrong moment shows up in the status word and on `irq` within a cycle of the transfer. The bench samples status only well after each frame, so it reports the wrong flag at the next status read. Interrupt-mode errors appear on the `irq` pin at the first frame in the wrong mode.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int ADDR_W = 2;
  localparam int MODE_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_BUF  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [MODE_W-1:0] MODE_OFF  = 3'b000;
  localparam logic [MODE_W-1:0] MODE_SYNC = 3'b001;

  typedef struct packed {
    logic              tx_en;
    logic              err_irq;
    logic              rx_on;
    logic [MODE_W-1:0] mode;
  } ctrl_t;
endpackage

// File: rtl/ssr_rst_sync.sv
module ssr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 2'b00;
    else        q <= {q[0], 1'b1};
  end
  assign srst_n = q[1];
endmodule

// File: rtl/ssr_sync_edge.sv
module ssr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sdat_in,
  output logic rise,
  output logic dat
);
  logic [STAGES-1:0] ck_q, dt_q;
  logic              ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q    <= '0;
      dt_q    <= '0;
      ck_prev <= 1'b0;
    end else begin
      ck_q    <= {ck_q[STAGES-2:0], sclk_in};
      dt_q    <= {dt_q[STAGES-2:0], sdat_in};
      ck_prev <= ck_q[STAGES-1];
    end
  end

  assign rise = ck_q[STAGES-1] & ~ck_prev;
  assign dat  = dt_q[STAGES-1];
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         rise,
  input  logic         din,
  output logic         done,
  output logic [W-1:0] frame
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sr, sr_d, frame_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             done_d;

  always_comb begin
    sr_d    = sr;
    cnt_d   = cnt;
    frame_d = frame;
    done_d  = 1'b0;
    if (!active) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (rise) begin
      sr_d = {din, sr[W-1:1]};
      if (cnt == LAST) begin
        cnt_d   = '0;
        done_d  = 1'b1;
        frame_d = {din, sr[W-1:1]};
      end else begin
        cnt_d = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      cnt   <= '0;
      frame <= '0;
      done  <= 1'b0;
    end else begin
      sr    <= sr_d;
      cnt   <= cnt_d;
      frame <= frame_d;
      done  <= done_d;
    end
  end
endmodule

// File: rtl/ssr_regs.sv
module ssr_regs
  import ssr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              frame_done,
  input  logic [W-1:0]      frame,
  output logic [W-1:0]      rdata,
  output logic              active,
  output logic              rx_on,
  output logic              err_irq,
  output logic              full,
  output logic              ovr,
  output logic              irq
);
  ctrl_t          ctrl, ctrl_d;
  logic [W-1:0]   rbuf, rbuf_d;
  logic           full_d, ovr_d, irq_d;
  logic           wr_ctrl, wr_stat, rd_buf, clr_rx;
  logic           rx_evt, ovr_evt, irq_set;
  logic           unused_bits;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign rd_buf  = rd_en && (addr == A_BUF);
  assign clr_rx  = wr_ctrl && !wdata[3];
  assign unused_bits = ^{wdata[W-1:6]};

  assign rx_evt  = frame_done && !clr_rx;
  assign ovr_evt = rx_evt && full && !rd_buf;
  assign irq_set = ctrl.err_irq ? ovr_evt : rx_evt;

  always_comb begin
    ctrl_d = ctrl;
    if (wr_ctrl) begin
      ctrl_d.mode    = wdata[MODE_W-1:0];
      ctrl_d.rx_on   = wdata[3];
      ctrl_d.err_irq = wdata[4];
      ctrl_d.tx_en   = (wdata[MODE_W-1:0] == MODE_SYNC) && wdata[5];
    end
  end

  always_comb begin
    rbuf_d = rbuf;
    full_d = full;
    ovr_d  = ovr;
    if (clr_rx) begin
      rbuf_d = '0;
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end else begin
      if (rd_buf)  full_d = 1'b0;
      if (rx_evt) begin
        rbuf_d = frame;
        full_d = 1'b1;
      end
      if (ovr_evt) ovr_d = 1'b1;
    end
  end

  always_comb begin
    irq_d = irq;
    if (wr_stat && !wdata[2]) irq_d = 1'b0;
    if (irq_set)              irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      rbuf <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      ctrl <= ctrl_d;
      rbuf <= rbuf_d;
      full <= full_d;
      ovr  <= ovr_d;
      irq  <= irq_d;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = W'({ctrl.tx_en, ctrl.err_irq, ctrl.rx_on, ctrl.mode});
      A_BUF:   rdata = rbuf;
      A_STAT:  rdata = W'({irq, ovr, full});
      default: rdata = '0;
    endcase
  end

  assign active  = (ctrl.mode == MODE_SYNC) && ctrl.rx_on;
  assign rx_on   = ctrl.rx_on;
  assign err_irq = ctrl.err_irq;
endmodule

// File: rtl/ssr_rx.sv
module ssr_rx
  import ssr_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              sdat_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              irq
);
  logic         srst_n, rise, dat, active, done;
  logic         rx_on, err_irq, full, ovr;
  logic [W-1:0] frame;

  ssr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  ssr_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(srst_n), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .rise(rise), .dat(dat)
  );

  ssr_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(srst_n), .active(active), .rise(rise), .din(dat),
    .done(done), .frame(frame)
  );

  ssr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .frame_done(done), .frame(frame), .rdata(rdata),
    .active(active), .rx_on(rx_on), .err_irq(err_irq), .full(full),
    .ovr(ovr), .irq(irq)
  );
endmodule

// File: rtl/ssr_rx_chk.sv
module ssr_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic active,
  input logic full,
  input logic ovr,
  input logic rx_on,
  input logic err_irq,
  input logic irq
);
  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($past(done) && $past(full)));
  // R5
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> !rx_on);
  // R2
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(done));
  // R9
  idle_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(active));
  // R7
  err_irq_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $past(err_irq)) |-> ovr);
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done));
endmodule

bind ssr_rx ssr_rx_chk u_chk (
  .clk(clk), .rst_n(srst_n), .done(done), .active(active), .full(full),
  .ovr(ovr), .rx_on(rx_on), .err_irq(err_irq), .irq(irq)
);

// File: tb/ssr_rx_tb.sv
module ssr_rx_tb;
  logic       clk, rst_n, sclk_in, sdat_in, wr_en, rd_en, irq;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  int n_chk, n_fail;
  bit finished;

  ssr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // each entry: {frame sent, expected buffer, expected status after frame}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 8'h00, 8'h05}, {8'hFF, 8'hFF, 8'h05}, {8'hA5, 8'hA5, 8'h05},
    {8'h5A, 8'h5A, 8'h05}, {8'h01, 8'h01, 8'h05}, {8'h80, 8'h80, 8'h05}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdat_in = b[i]; sclk_in = 1'b0;
      repeat (6) @(negedge clk);
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    sclk_in = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; sclk_in = 1'b0; sdat_in = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd1, v); check("R1 buf", v, 8'h00);
    rd(2'd2, v); check("R1 status", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    wr(2'd0, 8'h09);
    for (int k = 0; k < 6; k++) begin
      send_bits(VEC[k][23:16], 8);
      rd(2'd2, v); check("R2 R6 status after frame", v, VEC[k][7:0]);
      rd(2'd1, v); check("R2 buffer data", v, VEC[k][15:8]);
      rd(2'd2, v); check("R3 status after buffer read", v, 8'h04);
      wr(2'd2, 8'h00);
      check("R8 irq cleared", {7'd0, irq}, 8'h00);
    end

    // overrun, normal interrupt mode
    send_bits(8'h3C, 8);
    send_bits(8'hC3, 8);
    rd(2'd2, v); check("R4 R6 status overrun", v, 8'h07);
    rd(2'd1, v); check("R4 buffer overwritten", v, 8'hC3);
    rd(2'd2, v); check("R3 overrun kept after read", v, 8'h06);
    wr(2'd0, 8'h01);
    rd(2'd2, v); check("R5 flags cleared", v, 8'h04);
    rd(2'd1, v); check("R5 buffer cleared", v, 8'h00);
    wr(2'd2, 8'h00);

    // error-only interrupt mode
    wr(2'd0, 8'h19);
    send_bits(8'h11, 8);
    rd(2'd2, v); check("R7 no irq without overrun", v, 8'h01);
    check("R7 irq pin low", {7'd0, irq}, 8'h00);
    send_bits(8'h22, 8);
    rd(2'd2, v); check("R7 irq on overrun", v, 8'h07);
    check("R7 irq pin high", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h04);
    check("R8 write of one keeps irq", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R8 irq cleared only", v, 8'h03);

    // reception blocked
    wr(2'd0, 8'h00);
    send_bits(8'h77, 8);
    rd(2'd2, v); check("R9 port off no frame", v, 8'h00);
    wr(2'd0, 8'h0A);
    send_bits(8'h77, 8);
    rd(2'd2, v); check("R9 wrong mode no frame", v, 8'h00);
    wr(2'd0, 8'h01);
    send_bits(8'h77, 8);
    rd(2'd2, v); check("R9 rx disabled no frame", v, 8'h00);
    wr(2'd0, 8'h09);
    send_bits(8'hFF, 4);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h09);
    send_bits(8'h96, 8);
    rd(2'd1, v); check("R9 partial bits discarded", v, 8'h96);

    // transmit enable shares the mode field
    wr(2'd0, 8'h29);
    rd(2'd0, v); check("R10 tx_en kept in sync mode", v, 8'h29);
    wr(2'd0, 8'h20);
    rd(2'd0, v); check("R10 tx_en cleared mode off", v, 8'h00);
    wr(2'd0, 8'h2A);
    rd(2'd0, v); check("R10 tx_en cleared other mode", v, 8'h0A);

    finish_run();
  end
endmodule